// File: doc/BRIEF.md
# Transmit Sync Locator

This block keeps track of where the transmit system bus currently is inside its frame. A counter advances one position per bit clock through a 193-bit (T1) or 256-bit (E1) frame, and a second counter tracks the frame number within a multiframe. The frame-sync and multiframe-sync strobes can be placed at any single bit of the frame. The position is a 10-bit location: a 7-bit time-slot offset forms the upper bits and a 3-bit bit offset forms the lower bits. The frame strobe and the multiframe strobe both use this same location.

In generate mode the block only drives the strobes and ignores its sync inputs. In accept mode, external frame-sync and multiframe-sync pulses are compared with the programmed location. A pulse that arrives anywhere else raises a one-cycle misalignment flag, and the counters are reloaded so that the cycle of the pulse becomes the programmed location. Multiframe lengths of 12, 24 and 16 frames cover the superframe, extended superframe and E1 CRC multiframe formats.

Top module: `tx_sync_locator`

## Requirements
- R1: While rst_n is low, fsync_out, msync_out and align_err are 0, and bit_pos and frame_num are 0.
- R2: bit_pos advances by one per clock from 0 to L-1 and then returns to 0, where L is 193 when line_e1=0 and 256 when line_e1=1. frame_num advances by one each time bit_pos returns to 0.
- R3: The sync location equals ts_ofs*8 + bit_ofs: the time slot is in bits [9:3] and the bit offset in bits [2:0]. Bit offset code 0 selects the first bit of a slot, code 7 the eighth, and ts_ofs=0 with bit_ofs=0 selects the first bit of the frame (the T1 framing bit).
- R4: A location at or beyond L wraps modulo L.
- R5: fsync_out is high for exactly one clock. It is high in the cycle after the one in which bit_pos equals the location, which gives one strobe per frame.
- R6: msync_out follows the timing of fsync_out but only fires when frame_num was 0. frame_num counts modulo 12 for mf_sel=00, 24 for 01 and 16 for 10 and 11, so exactly one strobe occurs per multiframe.
- R7: When accept_mode=0, fsync_in and msync_in have no effect: align_err stays 0 and bit_pos keeps counting.
- R8: In accept mode, an fsync_in pulse in the cycle where bit_pos equals the location gives no align_err and does not disturb counting.
- R9: In accept mode, an fsync_in or msync_in pulse at any other bit_pos sets align_err for one clock in the following cycle. bit_pos then becomes location+1 (mod L).
- R10: In accept mode, msync_in reloads the frame counter so that the pulse cycle lies in frame 0. align_err is set if frame_num was not 0 at the pulse. A pulse at the location in frame 0 gives no flag and produces msync_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| line_e1 | input | 1 | 0: 193-bit frame, 1: 256-bit frame |
| mf_sel | input | 2 | Multiframe length: 00=12, 01=24, 10/11=16 |
| accept_mode | input | 1 | 1: check and align to incoming sync pulses |
| bit_ofs | input | 3 | Bit offset within the time slot |
| ts_ofs | input | 7 | Time-slot offset |
| fsync_in | input | 1 | Incoming frame-sync pulse (accept mode) |
| msync_in | input | 1 | Incoming multiframe-sync pulse (accept mode) |
| fsync_out | output | 1 | Frame-sync strobe |
| msync_out | output | 1 | Multiframe-sync strobe |
| align_err | output | 1 | One-cycle flag for a misplaced incoming pulse |
| bit_pos | output | 8 | Current bit position in the frame |
| frame_num | output | 5 | Current frame number in the multiframe |

## Verification
The bench sweeps every bit offset against time slots that land early in the frame, near its end and far past it, for both frame lengths. A design that swapped the field order, dropped the modulo or counted one position too many would place the strobe at the wrong bit. Each multiframe length is run for a full multiframe. An off-by-one frame limit or a missing frame-0 gate shows up as a wrong number of multiframe strobes. In accept mode the bench fires aligned, misaligned and generate-mode pulses. A design that flagged a correct pulse, obeyed pulses in generate mode, or reloaded to the location instead of the position after it would diverge from the bench model on bit_pos or align_err.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  localparam int BIT_OFS_W     = 3;
  localparam int TS_OFS_W      = 7;
  localparam int LOC_W         = BIT_OFS_W + TS_OFS_W;
  localparam int T1_FRAME_BITS = 193;
  localparam int E1_FRAME_BITS = 256;
  localparam int POS_W         = $clog2(E1_FRAME_BITS);
  localparam int MF_MAX        = 24;
  localparam int FRM_W         = $clog2(MF_MAX);

  // frame length in bit clocks
  function automatic logic [POS_W:0] frame_len(logic e1);
    return e1 ? (POS_W+1)'(E1_FRAME_BITS) : (POS_W+1)'(T1_FRAME_BITS);
  endfunction

  // multiframe length in frames
  function automatic logic [FRM_W-1:0] mf_len(logic [1:0] sel);
    case (sel)
      2'b00:   return FRM_W'(12);
      2'b01:   return FRM_W'(24);
      default: return FRM_W'(16);
    endcase
  endfunction

  // location folded into the frame
  function automatic logic [POS_W-1:0] wrap_loc(logic [LOC_W-1:0] loc, logic e1);
    if (e1) return loc[POS_W-1:0];
    return POS_W'(loc % LOC_W'(T1_FRAME_BITS));
  endfunction

  // next position with wrap at the end of the frame
  function automatic logic [POS_W-1:0] step_pos(logic [POS_W-1:0] p, logic e1);
    if ({1'b0, p} >= frame_len(e1) - (POS_W+1)'(1)) return '0;
    return p + POS_W'(1);
  endfunction
endpackage

// File: rtl/tsl_pos_counter.sv
module tsl_pos_counter import tsl_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_e1,
  input  logic             reload,
  input  logic [POS_W-1:0] reload_pos,
  output logic [POS_W-1:0] pos,
  output logic             wrap_next
);
  logic [POS_W-1:0] pos_nxt;

  assign pos_nxt   = reload ? reload_pos : step_pos(pos, line_e1);
  assign wrap_next = (pos_nxt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pos <= '0;
    else        pos <= pos_nxt;
  end
endmodule

// File: rtl/tsl_frame_counter.sv
module tsl_frame_counter import tsl_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mf_sel,
  input  logic             advance,
  input  logic             restart,
  output logic [FRM_W-1:0] frm
);
  logic [FRM_W-1:0] last;

  assign last = mf_len(mf_sel) - FRM_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       frm <= '0;
    else if (restart) frm <= advance ? FRM_W'(1) : '0;
    else if (advance) frm <= (frm >= last) ? '0 : frm + FRM_W'(1);
  end
endmodule

// File: rtl/tsl_pulse_reg.sv
module tsl_pulse_reg #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= 1'b0;
      else        r <= d[i];
    end
    assign q[i] = r;
  end
endmodule

// File: rtl/tx_sync_locator.sv
module tx_sync_locator import tsl_pkg::*; (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 line_e1,
  input  logic [1:0]           mf_sel,
  input  logic                 accept_mode,
  input  logic [BIT_OFS_W-1:0] bit_ofs,
  input  logic [TS_OFS_W-1:0]  ts_ofs,
  input  logic                 fsync_in,
  input  logic                 msync_in,
  output logic                 fsync_out,
  output logic                 msync_out,
  output logic                 align_err,
  output logic [POS_W-1:0]     bit_pos,
  output logic [FRM_W-1:0]     frame_num
);
  localparam int NSTROBE = 3;

  // named internal events
  logic [POS_W-1:0] target;
  logic             pos_match;
  logic             frame_zero;
  logic             sync_seen;
  logic             mf_seen;
  logic             misalign;
  logic             frame_wrap;
  logic [NSTROBE-1:0] strobe_d, strobe_q;

  assign target     = wrap_loc({ts_ofs, bit_ofs}, line_e1);
  assign pos_match  = (bit_pos == target);
  assign frame_zero = (frame_num == '0);
  assign sync_seen  = accept_mode & (fsync_in | msync_in);
  assign mf_seen    = accept_mode & msync_in;
  assign misalign   = sync_seen & (~pos_match | (mf_seen & ~frame_zero));

  tsl_pos_counter u_pos (
    .clk        (clk),
    .rst_n      (rst_n),
    .line_e1    (line_e1),
    .reload     (sync_seen),
    .reload_pos (step_pos(target, line_e1)),
    .pos        (bit_pos),
    .wrap_next  (frame_wrap)
  );

  tsl_frame_counter u_frm (
    .clk     (clk),
    .rst_n   (rst_n),
    .mf_sel  (mf_sel),
    .advance (frame_wrap),
    .restart (mf_seen),
    .frm     (frame_num)
  );

  assign strobe_d = {misalign, pos_match & frame_zero, pos_match};

  tsl_pulse_reg #(.N(NSTROBE)) u_stb (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (strobe_d),
    .q     (strobe_q)
  );

  assign fsync_out = strobe_q[0];
  assign msync_out = strobe_q[1];
  assign align_err = strobe_q[2];
endmodule

// File: rtl/tsl_checker.sv
module tsl_checker import tsl_pkg::*; (
  input logic             clk,
  input logic             rst_n,
  input logic             line_e1,
  input logic [1:0]       mf_sel,
  input logic             accept_mode,
  input logic             fsync_out,
  input logic             msync_out,
  input logic             align_err,
  input logic [POS_W-1:0] bit_pos,
  input logic [FRM_W-1:0] frame_num,
  input logic [POS_W-1:0] target
);
  assert_pos_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, bit_pos} < frame_len(line_e1));

  assert_loc_in_frame_R4: assert property (@(posedge clk) disable iff (!rst_n)
    {1'b0, target} < frame_len(line_e1));

  assert_fsync_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_out |=> !fsync_out);

  assert_fsync_place_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fsync_out |-> $past(bit_pos) == $past(target));

  assert_msync_frame0_R6: assert property (@(posedge clk) disable iff (!rst_n)
    msync_out |-> (fsync_out && $past(frame_num) == '0));

  assert_frame_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_num < mf_len(mf_sel));

  assert_quiet_generate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !accept_mode |=> !align_err);

  assert_realign_R9: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> bit_pos == step_pos($past(target), $past(line_e1)));
endmodule

bind tx_sync_locator tsl_checker u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .line_e1     (line_e1),
  .mf_sel      (mf_sel),
  .accept_mode (accept_mode),
  .fsync_out   (fsync_out),
  .msync_out   (msync_out),
  .align_err   (align_err),
  .bit_pos     (bit_pos),
  .frame_num   (frame_num),
  .target      (target)
);

// File: tb/sim_tx_sync_locator.sv
`timescale 1ns/1ps
module sim_tx_sync_locator;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       line_e1 = 1'b0;
  logic [1:0] mf_sel = 2'b00;
  logic       accept_mode = 1'b0;
  logic [2:0] bit_ofs = '0;
  logic [6:0] ts_ofs = '0;
  logic       fsync_in = 1'b0;
  logic       msync_in = 1'b0;
  logic       fsync_out, msync_out, align_err;
  logic [7:0] bit_pos;
  logic [4:0] frame_num;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  int m_pos, m_frm;

  always #4 clk = ~clk;

  tx_sync_locator u0 (
    .clk(clk), .rst_n(rst_n), .line_e1(line_e1), .mf_sel(mf_sel),
    .accept_mode(accept_mode), .bit_ofs(bit_ofs), .ts_ofs(ts_ofs),
    .fsync_in(fsync_in), .msync_in(msync_in), .fsync_out(fsync_out),
    .msync_out(msync_out), .align_err(align_err), .bit_pos(bit_pos),
    .frame_num(frame_num)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int flen();
    return line_e1 ? 256 : 193;
  endfunction

  function automatic int mflen();
    return (mf_sel == 2'b00) ? 12 : (mf_sel == 2'b01) ? 24 : 16;
  endfunction

  // one clock: predict, advance, compare
  task automatic tick(input string ph);
    int L, ML, tgt, np, nfr;
    bit match, any, nf, nm, ne;
    L = flen(); ML = mflen();
    tgt = (int'(ts_ofs) * 8 + int'(bit_ofs)) % L;
    match = (m_pos == tgt);
    any = accept_mode && (fsync_in || msync_in);
    nf = match;
    nm = match && (m_frm == 0);
    ne = any && (!match || (msync_in && m_frm != 0));
    np = any ? (tgt + 1) % L : (m_pos + 1) % L;
    if (accept_mode && msync_in) nfr = (np == 0) ? 1 : 0;
    else nfr = (np == 0) ? (m_frm + 1) % ML : m_frm;
    @(negedge clk);
    m_pos = np; m_frm = nfr;
    chk(fsync_out === nf, "R5", int'(fsync_out), int'(nf));
    chk(msync_out === nm, "R6", int'(msync_out), int'(nm));
    chk(align_err === ne, ph, int'(align_err), int'(ne));
    chk(int'(bit_pos) == m_pos, "R2", int'(bit_pos), m_pos);
    chk(int'(frame_num) == m_frm, "R2", int'(frame_num), m_frm);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(fsync_out === 1'b0, "R1", int'(fsync_out), 0);
    chk(msync_out === 1'b0, "R1", int'(msync_out), 0);
    chk(align_err === 1'b0, "R1", int'(align_err), 0);
    chk(bit_pos === 8'd0, "R1", int'(bit_pos), 0);
    chk(frame_num === 5'd0, "R1", int'(frame_num), 0);
    rst_n = 1'b1;
    m_pos = 0; m_frm = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int ts_list[4] = '{0, 5, 31, 127};
    // location sweep: R3, R4, R5
    for (int e = 0; e < 2; e++) begin
      for (int b = 0; b < 8; b++) begin
        for (int t = 0; t < 4; t++) begin
          int L, raw, loc, cnt, prev;
          line_e1 = e[0]; bit_ofs = b[2:0]; ts_ofs = ts_list[t][6:0];
          accept_mode = 1'b0; mf_sel = 2'b00;
          do_reset();
          L = flen(); raw = ts_list[t] * 8 + b; loc = raw % L; cnt = 0;
          for (int k = 1; k <= L; k++) begin
            prev = int'(bit_pos);
            tick("R7");
            if (fsync_out) begin
              cnt++;
              chk(prev == loc, (raw >= L) ? "R4" : "R3", prev, loc);
            end
          end
          chk(cnt == 1, "R5", cnt, 1);
        end
      end
    end

    // multiframe lengths: R6
    for (int c = 0; c < 4; c++) begin
      int cnt, total;
      line_e1 = (c >= 2); mf_sel = c[1:0]; bit_ofs = 3'd2; ts_ofs = 7'd3;
      accept_mode = 1'b0;
      do_reset();
      total = mflen() * flen(); cnt = 0;
      for (int k = 1; k <= total; k++) begin
        tick("R6");
        if (msync_out) cnt++;
      end
      chk(cnt == 1, "R6", cnt, 1);
    end

    // sync inputs, location 19 in a 193-bit frame, 12-frame multiframe
    line_e1 = 1'b0; mf_sel = 2'b00; ts_ofs = 7'd2; bit_ofs = 3'd3; accept_mode = 1'b0;
    do_reset();
    while (m_pos != 50) tick("R7");
    fsync_in = 1'b1; msync_in = 1'b1;
    tick("R7");
    fsync_in = 1'b0; msync_in = 1'b0;
    chk(align_err === 1'b0, "R7", int'(align_err), 0);
    chk(int'(bit_pos) == 51, "R7", int'(bit_pos), 51);

    accept_mode = 1'b1;
    while (m_pos != 19) tick("R8");
    fsync_in = 1'b1;
    tick("R8");
    fsync_in = 1'b0;
    chk(align_err === 1'b0, "R8", int'(align_err), 0);
    chk(int'(bit_pos) == 20, "R8", int'(bit_pos), 20);

    while (m_pos != 50) tick("R9");
    fsync_in = 1'b1;
    tick("R9");
    fsync_in = 1'b0;
    chk(align_err === 1'b1, "R9", int'(align_err), 1);
    chk(int'(bit_pos) == 20, "R9", int'(bit_pos), 20);
    tick("R9");
    chk(align_err === 1'b0, "R9", int'(align_err), 0);

    while (m_pos != 19) tick("R10");
    chk(int'(frame_num) != 0, "R10", int'(frame_num), 2);
    msync_in = 1'b1;
    tick("R10");
    msync_in = 1'b0;
    chk(align_err === 1'b1, "R10", int'(align_err), 1);
    chk(int'(frame_num) == 0, "R10", int'(frame_num), 0);
    chk(int'(bit_pos) == 20, "R10", int'(bit_pos), 20);
    tick("R10");
    while (!(m_frm == 0 && m_pos == 19)) tick("R10");
    msync_in = 1'b1;
    tick("R10");
    msync_in = 1'b0;
    chk(align_err === 1'b0, "R10", int'(align_err), 0);
    chk(msync_out === 1'b1, "R10", int'(msync_out), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule